// File: doc/BRIEF.md
# External Interrupt Request Controller

This block is the front end for two active-low external interrupt pins of a small 8-bit microcontroller. Each pin is brought into the clock domain by a synchronizer. A per-channel request flag is then set in one of two ways. In level mode it is set on every cycle the pin is low. In edge mode it is set only on a high-to-low transition between two consecutive synchronized samples. Flags are gated by a per-source enable and a global enable. A small arbiter then presents one pending request to the core, with its fixed vector address and its source index.

Software reaches the block through a single-cycle write port. Address 0 is the control register. Bit 2i is the trigger mode of channel i (0 = level, 1 = edge) and bit 2i+1 is the request flag of channel i, so the default two channels use bits 0 to 3. Address 1 is the enable register. Bit i enables source i and bit 7 is the global enable.

The request output follows valid/ready rules, with `irq_ack` as ready. Once `irq_valid` is high, `irq_src` and `irq_vector` do not change until acknowledge. The only other way out is for the request to be withdrawn: its flag is cleared, or its enable or the global enable is removed. In that case `irq_valid` falls. An acknowledge completes the transfer. It is always followed by one cycle with `irq_valid` low, after which arbitration runs again.

Top module: `xirq_ctrl`

## Requirements
- R1: In level mode (mode bit 0) a channel's flag is set on every cycle its synchronized pin reads low. The flag stays set after the pin returns high, until software clears it.
- R2: In edge mode (mode bit 1) a flag is set only when the previous synchronized sample was high and the current one is low. A pin held low sets it once.
- R3: While reset is asserted, the synchronizer and the pin history load the current pin values, so no edge is seen on the first sample after reset.
- R4: A channel requests only when its flag, its enable bit (enable register bit i) and the global enable (bit 7) are all set.
- R5: Channel 0 presents vector 0x0003 with `irq_src`=0, and channel 1 presents vector 0x0013 with `irq_src`=1. `irq_vector` reads 0 while `irq_valid` is low.
- R6: When both channels request in the same cycle, channel 0 is presented first.
- R7: An acknowledge clears the flag of the presented channel if that channel is in edge mode. In level mode the flag is left unchanged.
- R8: A write to address 0 sets or clears either flag directly. When a hardware set falls in the same cycle as a write, the flag ends up set.
- R9: While `irq_valid` is high and `irq_ack` is low, `irq_src` and `irq_vector` hold. After an acknowledge, `irq_valid` is low for at least one cycle.
- R10: A falling pin raises `irq_valid` on the 4th rising clock edge after the change: two synchronizer stages, the flag, and the output register.
- R11: After reset, `irq_valid` is low, both modes are level, and all flags and enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | NCH (2) | Active-low external interrupt pins, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control register, 1 = enable register |
| cfg_wdata | input | 8 | Register write data |
| irq_valid | output | 1 | A request is presented |
| irq_ack | input | 1 | Core accepts the presented vector (ready) |
| irq_vector | output | 16 | Vector address of the presented request |
| irq_src | output | SRCW (1) | Index of the presented channel |

## Verification
The bench holds a pin low for a long time in each mode. In level mode the request keeps coming back after acknowledge; in edge mode it appears once, so the two trigger modes can be told apart. A second falling edge shows that edge mode re-arms. Both pins falling together exposes the fixed order. A late request from the higher-priority channel, arriving while the other channel is presented, shows that the presented source is held and not preempted. Enables are switched on one at a time with a flag latched, and software writes are made in the same cycle as a hardware set, to check the gating and the set-over-write precedence.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_W    = 8;
  localparam int GEN_BIT  = 7;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_EN   = 1'b1;

  function automatic int mode_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int flag_pos(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int NCH    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_n,
  output logic [NCH-1:0] samp
);
  logic [NCH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        chain_q[s] <= pin_n;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= pin_n;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign samp = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic samp,
  input  logic wr_en,
  input  logic wr_mode,
  input  logic wr_flag,
  input  logic ack_clr,
  output logic mode,
  output logic flag
);
  logic prev_q, mode_q, flag_q, hw_set, flag_d;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= pin_raw;
    else        prev_q <= samp;
  end

  assign hw_set = mode_q ? (prev_q & ~samp) : ~samp;

  always_comb begin
    flag_d = flag_q;
    if (ack_clr && mode_q) flag_d = 1'b0;
    if (wr_en)             flag_d = wr_flag;
    if (hw_set)            flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) mode_q <= wr_mode;
      flag_q <= flag_d;
    end
  end

  assign mode = mode_q;
  assign flag = flag_q;

  assert_level_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !samp) |=> flag_q);

  assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !flag_q && !(wr_en && wr_flag) && !(prev_q && !samp)) |=> !flag_q);

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && ack_clr && !wr_en && !(prev_q && !samp)) |=> !flag_q);
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
  parameter int NCH  = 2,
  parameter int SRCW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            ack,
  output logic            valid,
  output logic [SRCW-1:0] src,
  output logic [NCH-1:0]  ack_clr
);
  logic            valid_q;
  logic [SRCW-1:0] src_q, pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) pick = SRCW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
    end else if (valid_q) begin
      if (ack || !req[src_q]) valid_q <= 1'b0;
    end else if (|req) begin
      valid_q <= 1'b1;
      src_q   <= pick;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_clr
    assign ack_clr[i] = valid_q && ack && (src_q == SRCW'(i));
  end

  assign valid = valid_q;
  assign src   = src_q;

  assert_low_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && req[0]) |=> (valid_q && src_q == '0));

  assert_ack_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ack) |=> !valid_q);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int          NCH         = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter logic [15:0] VEC_STRIDE  = 16'h0010,
  localparam int         SRCW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            ext_int_n,
  input  logic                      cfg_we,
  input  logic                      cfg_addr,
  input  logic [xirq_pkg::REG_W-1:0] cfg_wdata,
  output logic                      irq_valid,
  input  logic                      irq_ack,
  output logic [15:0]               irq_vector,
  output logic [SRCW-1:0]           irq_src
);
  import xirq_pkg::*;

  logic [NCH-1:0] samp, mode, flag, en_q, req, ack_clr;
  logic           gen_q, ctrl_we;

  xirq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_int_n), .samp(samp)
  );

  assign ctrl_we = cfg_we && (cfg_addr == ADDR_CTRL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    xirq_chan u_ch (
      .clk(clk), .rst_n(rst_n), .pin_raw(ext_int_n[i]), .samp(samp[i]),
      .wr_en(ctrl_we), .wr_mode(cfg_wdata[mode_pos(i)]),
      .wr_flag(cfg_wdata[flag_pos(i)]), .ack_clr(ack_clr[i]),
      .mode(mode[i]), .flag(flag[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else if (cfg_we && cfg_addr == ADDR_EN) begin
      en_q  <= cfg_wdata[NCH-1:0];
      gen_q <= cfg_wdata[GEN_BIT];
    end
  end

  assign req = flag & en_q & {NCH{gen_q}};

  xirq_arb #(.NCH(NCH), .SRCW(SRCW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(irq_ack),
    .valid(irq_valid), .src(irq_src), .ack_clr(ack_clr)
  );

  assign irq_vector = irq_valid ? (VEC_BASE + VEC_STRIDE * 16'(irq_src)) : 16'h0000;

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> !irq_valid);

  assert_hold_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (!irq_valid || ($stable(irq_src) && $stable(irq_vector))));

  assert_vector_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == VEC_BASE + VEC_STRIDE * 16'(irq_src)));
endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = 2'b11;
  logic       we = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       valid;
  logic [15:0] vec;
  logic [0:0] src;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_int_n(pin), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .irq_valid(valid), .irq_ack(ack), .irq_vector(vec),
    .irq_src(src)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 valid", valid, 0);
    check("R11 vector", vec, 0);
    check("R5 vector idle", vec, 0);
  endtask

  task automatic t_level();
    wr(1, 8'h81);
    pin[0] = 1'b0;
    step(3);
    check("R10 not yet", valid, 0);
    step(1);
    check("R10 valid", valid, 1);
    check("R1 level vector", vec, 16'h0003);
    check("R5 src0", src, 0);
    pin[0] = 1'b1;
    step(6);
    check("R1 flag latched", valid, 1);
    wr(0, 8'h00);
    step(1);
    check("R8 sw clear", valid, 0);
  endtask

  task automatic t_edge();
    wr(0, 8'h01);
    pin[0] = 1'b0;
    step(4);
    check("R2 edge set", valid, 1);
    do_ack();
    check("R9 gap after ack", valid, 0);
    step(5);
    check("R2 no reset while low", valid, 0);
    check("R7 edge ack cleared", valid, 0);
    pin[0] = 1'b1;
    step(4);
    check("R2 rising no set", valid, 0);
    pin[0] = 1'b0;
    step(4);
    check("R2 second edge", valid, 1);
    do_ack();
    pin[0] = 1'b1;
    step(4);
  endtask

  task automatic t_gate();
    wr(1, 8'h01);
    pin[0] = 1'b0;
    step(6);
    check("R4 global off", valid, 0);
    wr(1, 8'h80);
    step(2);
    check("R4 source off", valid, 0);
    wr(1, 8'h81);
    step(1);
    check("R4 both on", valid, 1);
    do_ack();
    pin[0] = 1'b1;
    step(4);
  endtask

  task automatic t_prio();
    wr(0, 8'h05);
    wr(1, 8'h83);
    pin = 2'b00;
    step(4);
    check("R6 ch0 first", src, 0);
    check("R5 vec 0x0003", vec, 16'h0003);
    do_ack();
    check("R9 gap", valid, 0);
    step(1);
    check("R6 ch1 next", valid, 1);
    check("R5 src1", src, 1);
    check("R5 vec 0x0013", vec, 16'h0013);
    do_ack();
    step(4);
    check("R7 both cleared", valid, 0);
    pin = 2'b11;
    step(4);
  endtask

  task automatic t_hold();
    pin[1] = 1'b0;
    step(4);
    check("R9 ch1 shown", src, 1);
    pin[0] = 1'b0;
    step(6);
    check("R9 src held", src, 1);
    check("R9 vec held", vec, 16'h0013);
    check("R9 still valid", valid, 1);
    do_ack();
    step(1);
    check("R9 ch0 after ack", src, 0);
    check("R9 ch0 valid", valid, 1);
    do_ack();
    step(3);
    check("R7 idle", valid, 0);
    pin = 2'b11;
    step(4);
  endtask

  task automatic t_sw();
    wr(0, 8'h07);
    step(1);
    check("R8 sw set", valid, 1);
    check("R8 sw set src", src, 0);
    wr(0, 8'h05);
    step(1);
    check("R8 sw clear edge", valid, 0);
    wr(0, 8'h04);
    pin[0] = 1'b0;
    step(3);
    wr(0, 8'h04);
    step(3);
    check("R8 hw set wins", valid, 1);
    do_ack();
    step(1);
    check("R7 level not cleared", valid, 1);
    pin[0] = 1'b1;
    step(4);
    check("R1 latched after high", valid, 1);
    wr(0, 8'h04);
    step(1);
    check("R8 clear level", valid, 0);
  endtask

  task automatic t_hist();
    pin[0] = 1'b0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    check("R11 valid after reset", valid, 0);
    wr(0, 8'h01);
    wr(0, 8'h01);
    wr(1, 8'h81);
    step(5);
    check("R3 no spurious edge", valid, 0);
    pin[0] = 1'b1;
    step(4);
    pin[0] = 1'b0;
    step(4);
    check("R3 real edge seen", valid, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_level();
    t_edge();
    t_gate();
    t_prio();
    t_hold();
    t_sw();
    t_hist();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule